// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between a divider network and the output drivers of a clock generator. It receives a set of single-ended divided clocks and one CPU-rate divided clock, all produced from one fast clock. It passes them to the outputs or freezes them. Freezing is driven by two things. The first is an active-low power-down pin, which is accepted only after it is seen low on two successive rising edges of the CPU complement phase. The second is a stop request, raised either by an active-low stop pin or by a software stop bit.

Every output changes state only on its own clock edges, so a shortened pulse never reaches a pin. A single-ended output freezes low at its next falling edge. A differential CPU pair freezes with the true leg driven high and the complement leg released. In power-down, a per-pair bit can release both legs instead. When power-down is withdrawn, a restart delay runs first. Each output then resumes on its own next edge, with a full-width first phase.

Top module: `clk_stop_gate`

## Requirements
- R1: Power-down takes effect only after the synchronised `pd_n` is low at two successive falling edges of `cpu_in` (the rising edges of the complement phase). A low lasting only one such edge leaves every output running.
- R2: In power-down, every single-ended output goes low and stays low. An output only ever falls when its source clock falls, so each high pulse it emits lasts the full source high time.
- R3: In power-down, a pair whose `dif_pd_tri` bit is 0 drives `dif_t` high (`dif_t_oe`=1) and releases the complement (`dif_c_oe`=0). A pair whose bit is 1 releases both legs.
- R4: `se_oe` follows `se_en` bit for bit. A pair with `dif_en`=0 has both `dif_t_oe` and `dif_c_oe` at 0.
- R5: The stop request is active when `stop_n` is low or `sw_stop` is 1. Only outputs whose stoppable bit is 1 stop under it; the others keep running.
- R6: A stoppable pair under a stop request holds `dif_t` high with `dif_t_oe`=1 and `dif_c_oe`=0, whatever its `dif_pd_tri` bit says.
- R7: After `pd_n` returns high, outputs stay frozen for RESTART_CYCLES fast-clock cycles. After that, each output restarts on its own next edge, so no short first pulse appears.
- R8: While running, `se_out` equals `se_in` delayed by one fast-clock cycle, `dif_t` equals `cpu_in` delayed by one cycle, and `dif_c` is its inverse. During reset, `se_out` is 0, `dif_t` is 1 and `dif_c_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock from which all divided inputs are derived |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_n | input | 1 | Active-low power-down pin, asynchronous |
| stop_n | input | 1 | Active-low stop pin, asynchronous |
| sw_stop | input | 1 | Software stop request bit |
| cpu_in | input | 1 | Divided CPU-rate clock (true phase) |
| se_in | input | N_SE | Divided single-ended clocks |
| se_en | input | N_SE | Single-ended output enables |
| se_stoppable | input | N_SE | 1 = output stops on stop request |
| dif_en | input | N_DIF | Differential pair enables |
| dif_stoppable | input | N_DIF | 1 = pair stops on stop request |
| dif_pd_tri | input | N_DIF | 1 = release both legs in power-down |
| se_out | output | N_SE | Gated single-ended clocks |
| se_oe | output | N_SE | Single-ended drive enables |
| dif_t | output | N_DIF | Gated true leg per pair |
| dif_c | output | N_DIF | Gated complement leg per pair |
| dif_t_oe | output | N_DIF | True-leg drive enables |
| dif_c_oe | output | N_DIF | Complement-leg drive enables |

## Verification
The hardest case to reach is a power-down pulse that is seen at exactly one complement edge. A slightly longer pulse crosses the two-sample threshold and changes the result entirely. The bench holds `pd_n` low for exactly one CPU period, which is four fast cycles. After synchronisation, that window contains exactly one falling edge of `cpu_in`, so the qualifier collects a single low sample. The bench then checks that all outputs keep following their sources. A pulse-width monitor runs through every scenario, including stops and restarts. It flags any high pulse on a single-ended output, or any low pulse on a true leg, that is shorter than its source phase.

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int N_SE           = 3,
  parameter int N_DIF          = 2,
  parameter int RESTART_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             stop_n,
  input  logic             sw_stop,
  input  logic             cpu_in,
  input  logic [N_SE-1:0]  se_in,
  input  logic [N_SE-1:0]  se_en,
  input  logic [N_SE-1:0]  se_stoppable,
  input  logic [N_DIF-1:0] dif_en,
  input  logic [N_DIF-1:0] dif_stoppable,
  input  logic [N_DIF-1:0] dif_pd_tri,
  output logic [N_SE-1:0]  se_out,
  output logic [N_SE-1:0]  se_oe,
  output logic [N_DIF-1:0] dif_t,
  output logic [N_DIF-1:0] dif_c,
  output logic [N_DIF-1:0] dif_t_oe,
  output logic [N_DIF-1:0] dif_c_oe
);
  localparam int CW = $clog2(RESTART_CYCLES + 1);

  logic [1:0] pd_sy, st_sy;
  logic       cpu_prev, seen_low, pd_hold;
  logic [CW-1:0] rcnt;

  wire pd_s      = pd_sy[1];
  wire stop_s    = st_sy[1];
  wire cpu_fall  = cpu_prev & ~cpu_in;
  wire cpu_rise  = ~cpu_prev & cpu_in;
  wire pd_active = pd_hold | (rcnt != '0);
  wire stop_req  = sw_stop | ~stop_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_sy    <= 2'b11;
      st_sy    <= 2'b11;
      cpu_prev <= 1'b0;
    end else begin
      pd_sy    <= {pd_sy[0], pd_n};
      st_sy    <= {st_sy[0], stop_n};
      cpu_prev <= cpu_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_low <= 1'b0;
      pd_hold  <= 1'b0;
      rcnt     <= '0;
    end else if (pd_s) begin
      seen_low <= 1'b0;
      pd_hold  <= 1'b0;
      if (pd_hold)           rcnt <= CW'(RESTART_CYCLES);
      else if (rcnt != '0)   rcnt <= rcnt - 1'b1;
    end else begin
      if (cpu_fall) begin
        seen_low <= 1'b1;
        if (seen_low) pd_hold <= 1'b1;
      end
      if (rcnt != '0) rcnt <= rcnt - 1'b1;
    end
  end

  logic [N_SE-1:0] se_prev, se_g, se_gn, se_q;

  always_comb begin
    for (int i = 0; i < N_SE; i++) begin
      se_gn[i] = se_g[i];
      if (se_g[i] && (pd_active || (se_stoppable[i] && stop_req)) && se_prev[i] && !se_in[i])
        se_gn[i] = 1'b0;
      else if (!se_g[i] && !(pd_active || (se_stoppable[i] && stop_req)) && !se_prev[i] && se_in[i])
        se_gn[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se_prev <= '1;
      se_g    <= '0;
      se_q    <= '0;
    end else begin
      se_prev <= se_in;
      se_g    <= se_gn;
      se_q    <= se_gn & se_in;
    end
  end

  logic [N_DIF-1:0] dg, dgn, dt_q, dc_q;

  always_comb begin
    for (int j = 0; j < N_DIF; j++) begin
      dgn[j] = dg[j];
      if (dg[j] && (pd_active || (dif_stoppable[j] && stop_req)) && cpu_rise)
        dgn[j] = 1'b0;
      else if (!dg[j] && !(pd_active || (dif_stoppable[j] && stop_req)) && cpu_fall)
        dgn[j] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dg   <= '0;
      dt_q <= '1;
      dc_q <= '0;
    end else begin
      dg <= dgn;
      for (int j = 0; j < N_DIF; j++) begin
        dt_q[j] <= dgn[j] ? cpu_in  : 1'b1;
        dc_q[j] <= dgn[j] ? ~cpu_in : 1'b0;
      end
    end
  end

  assign se_out   = se_q;
  assign se_oe    = se_en;
  assign dif_t    = dt_q;
  assign dif_c    = dc_q;
  assign dif_c_oe = dif_en & dg;
  assign dif_t_oe = dif_en & ~(~dg & {N_DIF{pd_active}} & dif_pd_tri);
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int N_SE  = 3,
  parameter int N_DIF = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_in,
  input logic             pd_s,
  input logic             pd_hold,
  input logic [N_SE-1:0]  se_in,
  input logic [N_SE-1:0]  se_out,
  input logic [N_DIF-1:0] dif_t,
  input logic [N_DIF-1:0] dif_t_oe,
  input logic [N_DIF-1:0] dif_c_oe
);
  AST_PD_ON_COMP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_hold) |-> (!$past(cpu_in) && $past(cpu_in, 2) && !$past(pd_s))); // R1

  for (genvar i = 0; i < N_SE; i++) begin : g_se
    AST_SE_FALL_WITH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(se_out[i]) |-> !$past(se_in[i])); // R2
    AST_SE_RISE_WITH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(se_out[i]) |-> ($past(se_in[i]) && !$past(se_in[i], 2))); // R7
  end

  for (genvar j = 0; j < N_DIF; j++) begin : g_dif
    AST_DIF_TRUE_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (dif_t_oe[j] && !dif_c_oe[j]) |-> dif_t[j]); // R3
    AST_DIF_COMP_NEEDS_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
      dif_c_oe[j] |-> dif_t_oe[j]); // R6
  end
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.N_SE(N_SE), .N_DIF(N_DIF)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_in(cpu_in), .pd_s(pd_s), .pd_hold(pd_hold),
  .se_in(se_in), .se_out(se_out), .dif_t(dif_t), .dif_t_oe(dif_t_oe), .dif_c_oe(dif_c_oe)
);

// File: tb/sim_clk_stop_gate.sv
`timescale 1ns/1ps
module sim_clk_stop_gate;
  localparam int CLK_PERIOD = 10;
  localparam int RESTART    = 64;

  logic clk = 0, rst_n = 0, pd_n = 1, stop_n = 1, sw_stop = 0;
  logic [2:0] se_en = 3'b111, se_stoppable = 3'b101;
  logic [1:0] dif_en = 2'b11, dif_stoppable = 2'b10, dif_pd_tri = 2'b10;
  logic [2:0] se_out, se_oe;
  logic [1:0] dif_t, dif_c, dif_t_oe, dif_c_oe;
  logic [4:0] cnt = 0;
  logic cpu_in;
  logic [2:0] se_in;
  int checks = 0, errors = 0;
  bit done = 0;

  assign se_in[0] = (cnt % 4) < 2;
  assign se_in[1] = (cnt % 6) < 3;
  assign se_in[2] = (cnt % 8) < 4;
  assign cpu_in   = (cnt % 4) >= 2;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cnt <= (cnt == 23) ? 5'd0 : cnt + 5'd1;

  clk_stop_gate #(.N_SE(3), .N_DIF(2), .RESTART_CYCLES(RESTART)) u0 (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .stop_n(stop_n), .sw_stop(sw_stop),
    .cpu_in(cpu_in), .se_in(se_in), .se_en(se_en), .se_stoppable(se_stoppable),
    .dif_en(dif_en), .dif_stoppable(dif_stoppable), .dif_pd_tri(dif_pd_tri),
    .se_out(se_out), .se_oe(se_oe), .dif_t(dif_t), .dif_c(dif_c),
    .dif_t_oe(dif_t_oe), .dif_c_oe(dif_c_oe));

  int hl [3];
  int bad [3];
  int tlow, tbad;
  initial begin
    for (int i = 0; i < 3; i++) begin hl[i] = 0; bad[i] = 0; end
    tlow = 0; tbad = 0;
  end
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      for (int i = 0; i < 3; i++) begin
        if (se_out[i]) hl[i]++;
        else begin
          if (hl[i] != 0 && hl[i] != (i + 2)) bad[i]++;
          hl[i] = 0;
        end
      end
      if (!dif_t[0]) tlow++;
      else begin
        if (tlow != 0 && tlow != 2) tbad++;
        tlow = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #2; end
  endtask

  task automatic follow(input int n, input logic [2:0] se_mask, input logic [1:0] d_mask, input string req);
    int miss = 0;
    int a = 0, e = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      if ((se_out & se_mask) != (se_in & se_mask) ||
          (dif_t & d_mask) != ({2{cpu_in}} & d_mask) ||
          (dif_c & d_mask) != ({2{~cpu_in}} & d_mask)) begin
        if (miss == 0) begin a = {se_out, dif_t}; e = {se_in & se_mask, {2{cpu_in}} & d_mask}; end
        miss++;
      end
    end
    chk(miss == 0, req, a, e);
  endtask

  task automatic t_reset();
    @(posedge clk); #2;
    chk(se_out == 3'b000, "R8 reset se_out", se_out, 0);
    chk(dif_t == 2'b11 && dif_c_oe == 2'b00, "R8 reset dif", {dif_t, dif_c_oe}, 4'b1100);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_run();
    tick(20);
    follow(24, 3'b111, 2'b11, "R8 running follow");
    chk(dif_c_oe == 2'b11 && dif_t_oe == 2'b11, "R8 pair oe", {dif_t_oe, dif_c_oe}, 4'hF);
  endtask

  task automatic t_glitch();
    @(negedge clk); pd_n = 0;
    repeat (4) @(negedge clk);
    pd_n = 1;
    follow(40, 3'b111, 2'b11, "R1 single-sample pd ignored");
  endtask

  task automatic t_pd();
    int hi = 0;
    @(negedge clk); pd_n = 0;
    tick(30);
    for (int k = 0; k < 10; k++) begin @(posedge clk); #2; if (se_out != 0) hi++; end
    chk(hi == 0, "R2 pd se_out low", hi, 0);
    chk(se_oe == 3'b111, "R2 pd se_oe kept", se_oe, 7);
    chk(dif_t[0] && dif_t_oe[0] && !dif_c_oe[0], "R3 pair0 true high comp off",
        {dif_t[0], dif_t_oe[0], dif_c_oe[0]}, 3'b110);
    chk(!dif_t_oe[1] && !dif_c_oe[1], "R3 pair1 both released", {dif_t_oe[1], dif_c_oe[1]}, 0);
  endtask

  task automatic t_restart();
    @(negedge clk); pd_n = 1;
    tick(20);
    chk(se_out == 0 && dif_c_oe == 0, "R7 still frozen in delay", {se_out, dif_c_oe}, 0);
    tick(RESTART);
    follow(24, 3'b111, 2'b11, "R7 resumed");
  endtask

  task automatic t_stop_pin();
    int h = 0;
    @(negedge clk); stop_n = 0;
    tick(30);
    for (int k = 0; k < 10; k++) begin @(posedge clk); #2; if (se_out[0] | se_out[2]) h++; end
    chk(h == 0, "R5 stoppable outputs low", h, 0);
    follow(24, 3'b010, 2'b01, "R5 free-running outputs run");
    chk(dif_t[1] && dif_t_oe[1] && !dif_c_oe[1], "R6 stopped pair ignores tri bit",
        {dif_t[1], dif_t_oe[1], dif_c_oe[1]}, 3'b110);
    @(negedge clk); stop_n = 1;
    tick(30);
    follow(24, 3'b111, 2'b11, "R5 release pin stop");
  endtask

  task automatic t_sw_stop();
    int h = 0;
    @(negedge clk); sw_stop = 1;
    tick(30);
    for (int k = 0; k < 10; k++) begin @(posedge clk); #2; if (se_out[0] | se_out[2]) h++; end
    chk(h == 0, "R5 software stop", h, 0);
    follow(24, 3'b010, 2'b01, "R5 software stop keeps free outputs");
    @(negedge clk); sw_stop = 0;
    tick(30);
    follow(24, 3'b111, 2'b11, "R5 release software stop");
  endtask

  task automatic t_enable();
    @(negedge clk); se_en = 3'b101; dif_en = 2'b01;
    tick(2);
    chk(se_oe == 3'b101, "R4 se_oe follows enable", se_oe, 5);
    chk(dif_t_oe[1] == 0 && dif_c_oe[1] == 0, "R4 disabled pair released", {dif_t_oe[1], dif_c_oe[1]}, 0);
    chk(dif_t_oe[0] && dif_c_oe[0], "R4 enabled pair driven", {dif_t_oe[0], dif_c_oe[0]}, 3);
    @(negedge clk); se_en = 3'b111; dif_en = 2'b11;
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    for (int i = 0; i < 3; i++) chk(bad[i] == 0, "R2 no short se pulse", bad[i], 0);
    chk(tbad == 0, "R7 no short true-leg low pulse", tbad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_run();
    t_glitch();
    t_pd();
    t_restart();
    t_stop_pin();
    t_sw_stop();
    t_enable();
    tick(10);
    finish_run();
  end
endmodule